// File: doc/BRIEF.md
# Byte-fed CRC-16 register engine

This block computes a 16-bit cyclic redundancy check over a stream of bytes that software writes, one at a time, through a small 16-bit register bus. It has three registers: a control register, a data-input register and a result register. The control register holds a write-one reset strobe and a read-only count of the bytes absorbed since the last reset. Each write to the data-input register folds its low byte into the running checksum in a single clock and advances the count. The result register shows the finished checksum at all times.

Software typically resets the engine, writes the bytes of a message, then reads the count to confirm that no byte was lost and reads the result. A fixed four-byte test vector gives a known result after reset, so a driver can prove the engine works before using it. The checksum uses the bit-reflected form of the 0x1021 generator, with bits taken least significant first. The starting value is 0xFFFF and the stored state is complemented on the way out.

Top module: `crc16_reg_engine`

## Requirements
- R1: After the synchronous active-low reset the control register reads 0x0000 and the result register reads 0x0000, which is the complemented starting value 0xFFFF.
- R2: A write to the control register (address 0) with bit 15 set returns the checksum state to 0xFFFF and the byte count to 0, whatever the other written bits hold.
- R3: Reads of the control register return the byte count in bits 11:0 and zero in bits 15:12, so the reset strobe always reads back as 0.
- R4: A write to the data-input register (address 1) folds only bits 7:0 of the written word into the checksum. Bits 15:8 have no effect on the result.
- R5: Each data-input write increments the byte count by one. The count saturates at 0xFFF, and the checksum keeps updating after the count has saturated.
- R6: After a reset, writing the bytes 0xCC, 0xF5, 0xF1 and 0xA7 yields a count of 4 and a result of 0x51DF.
- R7: For each data bit, taken least significant bit first, the state shifts right one place and is XORed with 0x8408 when the bit shifted out, XORed with the data bit, is 1. The result register (address 2) reads as the state XOR 0xFFFF.
- R8: A byte written on one clock edge is fully reflected in the count and the result from that edge on, so the very next read sees it.
- R9: Control writes with bit 15 clear, writes to the result register and writes or reads at the unused address 3 change neither the count nor the checksum. Address 3 reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 data input, 2 result, 3 unused |
| bus_wr | input | 1 | Write strobe for the selected register, one write per cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register, combinational from address and state |

## Verification
The engine is driven with the fixed four-byte test vector, with an all-zero and an all-ones byte stream, a walking-one byte pattern and an incrementing byte sequence. Together these separate a wrong generator, a wrong bit order, a wrong seed and a missing output complement, since each fault corrupts a different subset of them. The same low byte is also sent with different upper bits, to show that only bits 7:0 count. A run of more than 4095 bytes pushes the counter into saturation while the checksum is still compared. Reset strobes mixed with other control bits, and writes to the result and unused addresses, show which writes clear the state and which leave it untouched.

// File: rtl/crc16_eng_pkg.sv
// Package: shared register addresses and control-field positions for the
// byte-fed CRC-16 engine. Assumes a 2-bit word address on the register bus.
package crc16_eng_pkg;

    localparam int unsigned BUS_ADDR_W = 2;
    localparam int unsigned CLR_BIT    = 15;

    typedef enum logic [BUS_ADDR_W-1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_DIN    = 2'd1,
        ADDR_RESULT = 2'd2,
        ADDR_SPARE  = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/crc16_byte_fold.sv
// Module: crc16_byte_fold
// Combinational absorption of one byte into a reflected CRC state.
// Assumes LSB-first processing and a polynomial given in reflected form.
// The data byte is XORed into the low end of the state, then one shift and
// conditional reduction is done per bit.
module crc16_byte_fold #(
    parameter int unsigned       CRC_W  = 16,
    parameter int unsigned       BYTE_W = 8,
    parameter logic [CRC_W-1:0]  POLY   = 16'h8408
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [CRC_W-1:0]  crc_out
);

    localparam int unsigned PAD_W = CRC_W - BYTE_W;

    logic [CRC_W-1:0] stage [0:BYTE_W];

    // Inject the byte into the low bits before the shift chain.
    assign stage[0] = crc_in ^ {{PAD_W{1'b0}}, byte_in};

    // One shift-and-reduce step per data bit.
    for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
        assign stage[g+1] = stage[g][0] ? ((stage[g] >> 1) ^ POLY)
                                        : (stage[g] >> 1);
    end

    assign crc_out = stage[BYTE_W];

endmodule

// File: rtl/crc16_sat_counter.sv
// Module: crc16_sat_counter
// Counts absorbed bytes and saturates at all-ones.
// Assumes clear and increment never need to act together in one cycle. If
// both are raised, the clear wins.
module crc16_sat_counter #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic at_max;

    // Flag the saturated value so the increment can be blocked.
    assign at_max = (count == CNT_MAX);

    // Count register: reset and clear to zero, step up until saturated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && !at_max) begin
            count <= count + 1'b1;
        end
    end

    // R5: an increment below the ceiling adds exactly one
    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && count != CNT_MAX) |=> (count == $past(count) + 1'b1));

    // R5: once saturated the count stays there until cleared
    p_count_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && !clr) |=> (count == CNT_MAX));

    // R2: a clear request empties the count
    p_count_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

endmodule

// File: rtl/crc16_reg_engine.sv
// Module: crc16_reg_engine
// Register-mapped CRC-16 calculator fed one byte per bus write.
// Assumes a single-cycle write strobe and combinational read data. The
// control word carries a write-one clear strobe and the read-only byte count,
// the data word supplies the byte, and the result word returns the
// complemented state.
module crc16_reg_engine
    import crc16_eng_pkg::*;
#(
    parameter int unsigned          DATA_W = 16,
    parameter int unsigned          CNT_W  = 12,
    parameter int unsigned          BYTE_W = 8,
    parameter logic [DATA_W-1:0]    POLY   = 16'h8408,
    parameter logic [DATA_W-1:0]    SEED   = 16'hFFFF,
    parameter logic [DATA_W-1:0]    XOROUT = 16'hFFFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata
);

    logic [DATA_W-1:0] crc_state;
    logic [DATA_W-1:0] crc_next;
    logic [CNT_W-1:0]  byte_count;
    logic              clr_req;
    logic              feed_req;
    logic              wdata_unused;

    // Decode the two write actions that change state.
    assign clr_req  = bus_wr && (bus_addr == ADDR_CTRL) && bus_wdata[CLR_BIT];
    assign feed_req = bus_wr && (bus_addr == ADDR_DIN);

    // Bits between the byte and the strobe carry no function.
    assign wdata_unused = ^bus_wdata[DATA_W-2:BYTE_W];

    crc16_byte_fold #(
        .CRC_W  (DATA_W),
        .BYTE_W (BYTE_W),
        .POLY   (POLY)
    ) u_fold (
        .crc_in  (crc_state),
        .byte_in (bus_wdata[BYTE_W-1:0]),
        .crc_out (crc_next)
    );

    crc16_sat_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_req),
        .inc   (feed_req),
        .count (byte_count)
    );

    // Checksum state: seeded on reset or clear, advanced on each byte write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_state <= SEED;
        end else if (clr_req) begin
            crc_state <= SEED;
        end else if (feed_req) begin
            crc_state <= crc_next;
        end
    end

    // Read mux: count in control, complemented state in result, else zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL:   bus_rdata[CNT_W-1:0] = byte_count;
            ADDR_RESULT: bus_rdata = crc_state ^ XOROUT;
            default:     bus_rdata = '0;
        endcase
    end

    // R2: a clear strobe reseeds the checksum
    p_clear_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (crc_state == SEED));

    // R9: writes that neither clear nor feed leave the checksum alone
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_req || feed_req) |=> $stable(crc_state));

    // R1: an empty count always pairs with the seeded checksum
    p_empty_is_seed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_count == '0) |-> (crc_state == SEED));

    // R8: a byte write changes the count or keeps it saturated on the next edge
    p_feed_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
        feed_req |=> (byte_count != '0));

endmodule

// File: tb/tb_crc16_reg_engine.sv
`timescale 1ns/1ps
module tb_crc16_reg_engine;

    logic        clk;
    logic        rst_n;
    logic [1:0]  bus_addr;
    logic        bus_wr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;

    int n_checks;
    int n_fails;
    bit done;

    // reference model state
    logic [15:0] m_crc;
    int          m_cnt;

    crc16_reg_engine dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // bit-serial reference, data bit combined with the outgoing state bit
    function automatic logic [15:0] ref_fold(logic [15:0] c, logic [7:0] b);
        for (int k = 0; k < 8; k++) begin
            if (c[0] ^ b[k]) c = (c >> 1) ^ 16'h8408;
            else             c = c >> 1;
        end
        return c;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // read control and result registers against the model
    task automatic compare_all(string req);
        bus_wr   = 1'b0;
        bus_addr = 2'd0;
        #0.5;
        check(req, bus_rdata, 16'(m_cnt));
        bus_addr = 2'd2;
        #0.5;
        check(req, bus_rdata, ~m_crc);
    endtask

    task automatic bus_write(logic [1:0] a, logic [15:0] d, string req);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        if (a == 2'd0 && d[15]) begin
            m_crc = 16'hFFFF;
            m_cnt = 0;
        end else if (a == 2'd1) begin
            m_crc = ref_fold(m_crc, d[7:0]);
            if (m_cnt < 4095) m_cnt++;
        end
        @(negedge clk);
        compare_all(req);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got 0x0000 expected 0x0001");
            summary();
        end
    end

    initial begin
        logic [15:0] r_a;
        n_checks = 0;
        n_fails  = 0;
        done     = 1'b0;
        rst_n    = 1'b0;
        bus_wr   = 1'b0;
        bus_addr = 2'd0;
        bus_wdata = 16'h0;
        m_crc = 16'hFFFF;
        m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        compare_all("R1");
        bus_addr = 2'd0; #0.5;
        check("R1", bus_rdata, 16'h0000);
        bus_addr = 2'd2; #0.5;
        check("R1", bus_rdata, 16'h0000);

        // R6: known-answer vector, constants written out
        bus_write(2'd1, 16'h00CC, "R6");
        bus_write(2'd1, 16'h00F5, "R6");
        bus_write(2'd1, 16'h00F1, "R6");
        bus_write(2'd1, 16'h00A7, "R6");
        bus_addr = 2'd0; #0.5;
        check("R6", bus_rdata, 16'h0004);
        bus_addr = 2'd2; #0.5;
        check("R6", bus_rdata, 16'h51DF);

        // R9: writes that must not touch state
        bus_write(2'd0, 16'h7FFF, "R9");
        bus_write(2'd2, 16'h1234, "R9");
        bus_write(2'd3, 16'hFFFF, "R9");
        bus_addr = 2'd3; #0.5;
        check("R9", bus_rdata, 16'h0000);
        bus_addr = 2'd2; #0.5;
        check("R9", bus_rdata, 16'h51DF);

        // R2 and R3: clear strobe with other bits set, strobe reads back 0
        bus_write(2'd0, 16'h8ABC, "R2");
        bus_addr = 2'd0; #0.5;
        check("R3", bus_rdata, 16'h0000);

        // R4: upper bits ignored, same low byte gives same result
        bus_write(2'd1, 16'hFA5C, "R4");
        bus_addr = 2'd2; #0.5;
        r_a = bus_rdata;
        bus_write(2'd0, 16'h8000, "R2");
        bus_write(2'd1, 16'h005C, "R4");
        bus_addr = 2'd2; #0.5;
        check("R4", bus_rdata, r_a);

        // R7 and R8: assorted byte patterns, compared after every write
        bus_write(2'd0, 16'h8000, "R2");
        for (int i = 0; i < 8; i++) bus_write(2'd1, 16'h0000, "R7");
        bus_write(2'd0, 16'h8000, "R2");
        for (int i = 0; i < 8; i++) bus_write(2'd1, 16'h00FF, "R7");
        bus_write(2'd0, 16'h8000, "R2");
        for (int i = 0; i < 8; i++) bus_write(2'd1, 16'(1 << i), "R7");
        bus_write(2'd0, 16'h8000, "R2");
        for (int i = 0; i < 32; i++) bus_write(2'd1, 16'(i * 7 + 3), "R8");

        // R1: mid-stream hardware reset returns to the reset state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_crc = 16'hFFFF;
        m_cnt = 0;
        compare_all("R1");

        // R5: saturation of the byte count, checksum still moving
        for (int i = 0; i < 4100; i++) bus_write(2'd1, 16'(i), "R5");
        bus_addr = 2'd0; #0.5;
        check("R5", bus_rdata, 16'h0FFF);
        bus_write(2'd0, 16'h8000, "R2");

        @(negedge clk);
        done = 1'b1;
        summary();
    end

endmodule